// File: doc/BRIEF.md
# Run-Time Configurable Serial Transceiver

This block is a paired asynchronous serial transmitter and receiver. Its frame format is chosen at run time from four configuration inputs: a data length of 7 or 8 bits, one or two stop bits, and parity that is off, even or odd. Every frame opens with a single low start bit. The block sends data least significant bit first, then the parity bit when parity is on, then the stop bit or bits.

The transmitter takes a parallel character through a valid/ready handshake and shifts it out on `txd`. The receiver oversamples `rxd` using a tick that runs at 16 times the bit rate. For each frame it delivers the character and two error flags on a single-cycle valid pulse. Both directions time their bits from the same tick input, which stands in for a baud-rate generator.

The format can only change while the block is disabled. A master enable freezes the format registers, and they keep the value they held when the enable rose. Clearing the enable returns both directions to idle.

Top module: `uart_fmt_xcvr`

## Requirements
- R1: With `fmt_len8`=0, a frame carries 7 data bits. Transmit ignores `tx_data[7]`, and `rx_data[7]` is always 0.
- R2: With `fmt_len8`=1, a frame carries 8 data bits, and all 8 reach `rx_data`.
- R3: With `fmt_stop2`=0 the frame ends with one high stop bit. With `fmt_stop2`=1 it ends with two. Each bit lasts 16 ticks.
- R4: With `fmt_par_en`=0 no parity bit is sent, and `rx_par_err` stays 0 on every received frame.
- R5: With `fmt_par_en`=1 a parity bit follows the data. When `fmt_par_odd`=0, data plus parity hold an even number of ones. When `fmt_par_odd`=1 they hold an odd number. The receiver sets `rx_par_err` when the received parity bit breaks this rule.
- R6: On `txd` the line order is one low start bit, then data bit 0 upward, then parity if enabled, then the stop bits.
- R7: The receiver begins a frame on a high-to-low transition of `rxd`. It samples 8 ticks later to confirm the start bit and abandons the frame if the line is high again. After that it samples every 16 ticks.
- R8: `rx_frm_err` is set when any expected stop bit, first or second, is sampled low.
- R9: `rx_valid` is a one-cycle pulse per frame. `rx_data`, `rx_par_err` and `rx_frm_err` are valid with that pulse.
- R10: The format inputs take effect only while `en`=0. The block uses the value present when `en` rises, and changes made while `en`=1 have no effect.
- R11: `txd` idles high. `tx_ready` is 0 while `en`=0, and it is also 0 from the cycle after a character is accepted until the last stop bit has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Master enable; format locked while 1 |
| tick | input | 1 | Sampling enable, 16 per bit period |
| fmt_len8 | input | 1 | 0: 7 data bits, 1: 8 data bits |
| fmt_stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 0: even parity, 1: odd parity |
| tx_data | input | 8 | Character to transmit |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter can accept a character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle pulse: received frame complete |
| rx_par_err | output | 1 | Parity mismatch in this frame |
| rx_frm_err | output | 1 | Low stop bit in this frame |

## Verification
The hardest receive cases to reach from the ports are frames that only a faulty sender would produce. One is a two-stop-bit frame whose first stop bit is good and whose second is low. Another is a start pulse that ends before the mid-bit confirmation point. The block's own transmitter never produces either. For these cases the bench switches `rxd` away from the loopback and drives it from its own tick-timed serializer. It builds each frame arithmetically and then flips chosen bits. The regular frames run in loopback, sweeping all eight format combinations over several data patterns.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;
   typedef struct packed {
      logic len8;
      logic stop2;
      logic par_en;
      logic par_odd;
   } fmt_t;

   localparam int CHAR_W = 8;

   // parity bit that completes the character under the selected mode
   function automatic logic par_bit(input logic [CHAR_W-1:0] d, input fmt_t f);
      logic [CHAR_W-1:0] m;
      m = f.len8 ? d : {1'b0, d[CHAR_W-2:0]};
      return (^m) ^ f.par_odd;
   endfunction
endpackage

// File: rtl/uart_fmt_cfg.sv
module uart_fmt_cfg
   import uart_fmt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  fmt_t fmt_in,
   output fmt_t fmt
);
   // format follows the inputs only while disabled; frozen from the rising edge of en
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fmt <= '0;
      else if (!en) fmt <= fmt_in;
   end

   assert_fmt_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> $stable(fmt));
endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
   import uart_fmt_pkg::*;
#(
   parameter int OVS = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  fmt_t              fmt,
   input  logic [CHAR_W-1:0] din,
   input  logic              valid,
   output logic              ready,
   output logic              txd
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(CHAR_W);

   typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tstate_t;

   tstate_t           st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [CHAR_W-1:0] sh;
   logic              pbit;
   logic              stop_sec;
   logic              bit_end;
   logic [IDX_W-1:0]  last_idx;

   assign bit_end  = tick && (cnt == CNT_W'(OVS-1));
   assign last_idx = fmt.len8 ? IDX_W'(CHAR_W-1) : IDX_W'(CHAR_W-2);
   assign ready    = en && (st == T_IDLE);

   always_comb begin
      case (st)
         T_START: txd = 1'b0;
         T_DATA:  txd = sh[0];
         T_PAR:   txd = pbit;
         default: txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= T_IDLE; cnt <= '0; idx <= '0; sh <= '0; pbit <= 1'b0; stop_sec <= 1'b0;
      end else if (!en) begin
         st <= T_IDLE; cnt <= '0;
      end else if (st == T_IDLE) begin
         if (valid) begin
            st       <= T_START;
            cnt      <= '0;
            idx      <= '0;
            stop_sec <= 1'b0;
            sh       <= fmt.len8 ? din : {1'b0, din[CHAR_W-2:0]};
            pbit     <= par_bit(din, fmt);
         end
      end else if (tick) begin
         cnt <= bit_end ? '0 : cnt + 1'b1;
         if (bit_end) begin
            case (st)
               T_START: st <= T_DATA;
               T_DATA: begin
                  sh  <= sh >> 1;
                  idx <= idx + 1'b1;
                  if (idx == last_idx) st <= fmt.par_en ? T_PAR : T_STOP;
               end
               T_PAR: st <= T_STOP;
               T_STOP: begin
                  if (fmt.stop2 && !stop_sec) stop_sec <= 1'b1;
                  else                        st <= T_IDLE;
               end
               default: st <= T_IDLE;
            endcase
         end
      end
   end

   assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> !ready);
   assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> txd);
   assert_no_ready_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !ready);
endmodule

// File: rtl/uart_fmt_rx.sv
module uart_fmt_rx
   import uart_fmt_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  fmt_t              fmt,
   input  logic              rxd,
   output logic [CHAR_W-1:0] dout,
   output logic              dvalid,
   output logic              par_err,
   output logic              frm_err
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(CHAR_W);
   localparam int MID   = OVS / 2;

   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rstate_t;

   // input synchronizer, depth set by parameter
   logic [SYNC_STAGES-1:0] sync;
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync[gi] <= 1'b1;
            else        sync[gi] <= (gi == 0) ? rxd : sync[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   logic              line;
   logic              prev;
   rstate_t           st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [CHAR_W-1:0] acc;
   logic              pbad;
   logic              fbad;
   logic              stop_sec;
   logic              samp;
   logic [IDX_W-1:0]  last_idx;

   assign line     = sync[SYNC_STAGES-1];
   assign samp     = tick && (cnt == CNT_W'(OVS-1));
   assign last_idx = fmt.len8 ? IDX_W'(CHAR_W-1) : IDX_W'(CHAR_W-2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= R_IDLE; cnt <= '0; idx <= '0; acc <= '0; pbad <= 1'b0; fbad <= 1'b0;
         stop_sec <= 1'b0; prev <= 1'b1;
         dout <= '0; dvalid <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
      end else if (!en) begin
         st <= R_IDLE; cnt <= '0; prev <= 1'b1; dvalid <= 1'b0;
      end else begin
         dvalid <= 1'b0;
         if (tick) prev <= line;
         case (st)
            R_IDLE: if (tick && prev && !line) begin
               st <= R_START; cnt <= '0; idx <= '0; acc <= '0;
               pbad <= 1'b0; fbad <= 1'b0; stop_sec <= 1'b0;
            end
            R_START: if (tick) begin
               if (cnt == CNT_W'(MID-1)) begin
                  cnt <= '0;
                  st  <= line ? R_IDLE : R_DATA;
               end else cnt <= cnt + 1'b1;
            end
            default: if (tick) begin
               cnt <= samp ? '0 : cnt + 1'b1;
               if (samp) begin
                  case (st)
                     R_DATA: begin
                        acc[idx] <= line;
                        idx      <= idx + 1'b1;
                        if (idx == last_idx) st <= fmt.par_en ? R_PAR : R_STOP;
                     end
                     R_PAR: begin
                        pbad <= (line != par_bit(acc, fmt));
                        st   <= R_STOP;
                     end
                     default: begin
                        if (fmt.stop2 && !stop_sec) begin
                           stop_sec <= 1'b1;
                           fbad     <= !line;
                        end else begin
                           st      <= R_IDLE;
                           dvalid  <= 1'b1;
                           dout    <= acc;
                           par_err <= pbad;
                           frm_err <= fbad | !line;
                        end
                     end
                  endcase
               end
            end
         endcase
      end
   end

   assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |=> !dvalid);
   assert_msb_clear_7bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && !fmt.len8) |-> !dout[CHAR_W-1]);
   assert_no_par_err_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && !fmt.par_en) |-> !par_err);
endmodule

// File: rtl/uart_fmt_xcvr.sv
module uart_fmt_xcvr
   import uart_fmt_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       fmt_len8,
   input  logic       fmt_stop2,
   input  logic       fmt_par_en,
   input  logic       fmt_par_odd,
   input  logic [7:0] tx_data,
   input  logic       tx_valid,
   output logic       tx_ready,
   output logic       txd,
   input  logic       rxd,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   output logic       rx_par_err,
   output logic       rx_frm_err
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   fmt_t fmt_in, fmt;
   assign fmt_in = '{len8: fmt_len8, stop2: fmt_stop2, par_en: fmt_par_en, par_odd: fmt_par_odd};

   uart_fmt_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .en(en), .fmt_in(fmt_in), .fmt(fmt)
   );

   uart_fmt_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .fmt(fmt),
      .din(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
   );

   uart_fmt_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .fmt(fmt), .rxd(rxd),
      .dout(rx_data), .dvalid(rx_valid), .par_err(rx_par_err), .frm_err(rx_frm_err)
   );
endmodule

// File: tb/tb_uart_fmt_xcvr.sv
`timescale 1ns/100ps
module tb_uart_fmt_xcvr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       tick = 1'b0;
   logic       f_len8 = 1'b0, f_stop2 = 1'b0, f_pen = 1'b0, f_podd = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready, txd;
   logic       loop = 1'b1;
   logic       rxd_drv = 1'b1;
   logic       rxd;
   logic [7:0] rx_data;
   logic       rx_valid, rx_par_err, rx_frm_err;

   int checks = 0;
   int errors = 0;
   int npulse = 0;
   logic [7:0] cap_d = '0;
   logic       cap_p = 1'b0, cap_f = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) tick <= ~tick;
   assign rxd = loop ? txd : rxd_drv;

   uart_fmt_xcvr dut (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
      .fmt_len8(f_len8), .fmt_stop2(f_stop2), .fmt_par_en(f_pen), .fmt_par_odd(f_podd),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
      .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
   );

   always @(posedge clk) if (rx_valid) begin
      npulse <= npulse + 1;
      cap_d  <= rx_data;
      cap_p  <= rx_par_err;
      cap_f  <= rx_frm_err;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (n) begin
         @(posedge clk);
         while (!tick) @(posedge clk);
      end
   endtask

   // expected line frame: index 0 start, data LSB first, parity, stops
   task automatic build(input logic [7:0] d, input logic l, s, pe, po,
                        output logic [11:0] fr, output int n);
      int nd;
      logic [7:0] m;
      nd = l ? 8 : 7;
      m  = l ? d : {1'b0, d[6:0]};
      fr = '1;
      fr[0] = 1'b0;
      for (int i = 0; i < nd; i++) fr[1+i] = m[i];
      n = 1 + nd;
      if (pe) begin fr[n] = (^m) ^ po; n++; end
      n += s ? 2 : 1;
   endtask

   task automatic set_fmt(input logic l, s, pe, po);
      @(negedge clk);
      en = 1'b0;
      f_len8 = l; f_stop2 = s; f_pen = pe; f_podd = po;
      repeat (3) @(negedge clk);
      en = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // loopback frame: check each line bit at mid-bit, then the received result
   task automatic tx_frame(input logic [7:0] d, input logic l, s, pe, po);
      logic [11:0] fr;
      int n, base, nd;
      string r;
      build(d, l, s, pe, po, fr, n);
      nd = l ? 8 : 7;
      base = npulse;
      loop = 1'b1;
      @(negedge clk);
      tx_data = d; tx_valid = 1'b1;
      forever begin
         @(posedge clk);
         if (tx_ready) break;
      end
      @(negedge clk) tx_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         wait_ticks(i == 0 ? 8 : 16);
         #1;
         if (i == 0 || i <= nd) r = "R6";
         else if (pe && i == nd + 1) r = "R5";
         else r = "R3";
         chk(txd === fr[i], r, 32'(txd), 32'(fr[i]));
      end
      chk(tx_ready === 1'b0, "R11 busy in last stop", 32'(tx_ready), 0);
      wait_ticks(8);
      #1;
      chk(tx_ready === 1'b1, "R11 ready after stop", 32'(tx_ready), 1);
      chk(txd === 1'b1, "R11 idle high", 32'(txd), 1);
      repeat (4) @(negedge clk);
      chk(npulse == base + 1, "R9 one pulse", 32'(npulse - base), 1);
      chk(cap_d == (l ? d : {1'b0, d[6:0]}), l ? "R2 rx data" : "R1 rx data", 32'(cap_d),
          32'(l ? d : {1'b0, d[6:0]}));
      chk(cap_p == 1'b0, pe ? "R5 no par err" : "R4 no par err", 32'(cap_p), 0);
      chk(cap_f == 1'b0, "R3 no frm err", 32'(cap_f), 0);
   endtask

   // bench-driven receive frame
   task automatic rx_frame(input logic [11:0] fr, input int n, input logic [7:0] exp_d,
                           input logic exp_p, input logic exp_f, input string req);
      int base;
      base = npulse;
      loop = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk) rxd_drv = fr[i];
         wait_ticks(16);
      end
      @(negedge clk) rxd_drv = 1'b1;
      wait_ticks(24);
      @(negedge clk);
      chk(npulse == base + 1, {req, " R9 pulse"}, 32'(npulse - base), 1);
      chk(cap_d == exp_d, {req, " data"}, 32'(cap_d), 32'(exp_d));
      chk(cap_p == exp_p, {req, " par flag"}, 32'(cap_p), 32'(exp_p));
      chk(cap_f == exp_f, {req, " frm flag"}, 32'(cap_f), 32'(exp_f));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] pats [5];
      logic [11:0] fr;
      int n, base;
      pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};

      repeat (5) @(negedge clk);
      chk(txd === 1'b1, "R11 reset txd", 32'(txd), 1);
      chk(tx_ready === 1'b0, "R11 reset ready", 32'(tx_ready), 0);
      chk(rx_valid === 1'b0, "R9 reset valid", 32'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(tx_ready === 1'b0, "R11 ready low while disabled", 32'(tx_ready), 0);

      // sweep all eight formats (parity mode alternates)
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 5; p++) begin
            set_fmt(c[2], c[1], c[0], p[0]);
            tx_frame(pats[p], c[2], c[1], c[0], p[0]);
         end
      end

      // R10: format changes while enabled have no effect
      set_fmt(1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      f_len8 = 1'b1; f_stop2 = 1'b1; f_pen = 1'b1; f_podd = 1'b1;
      repeat (4) @(negedge clk);
      tx_frame(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);  // R10 old format still used
      set_fmt(1'b1, 1'b1, 1'b1, 1'b1);
      tx_frame(8'hC3, 1'b1, 1'b1, 1'b1, 1'b1);  // R10 new format after re-enable

      // R5: parity errors in both modes
      set_fmt(1'b1, 1'b0, 1'b1, 1'b0);
      build(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, fr, n);
      fr[9] = ~fr[9];
      rx_frame(fr, n, 8'h5A, 1'b1, 1'b0, "R5 even bad");
      set_fmt(1'b0, 1'b0, 1'b1, 1'b1);
      build(8'h13, 1'b0, 1'b0, 1'b1, 1'b1, fr, n);
      fr[8] = ~fr[8];
      rx_frame(fr, n, 8'h13, 1'b1, 1'b0, "R5 odd bad");

      // R8: framing errors on single stop, and on either of two stops
      set_fmt(1'b1, 1'b0, 1'b0, 1'b0);
      build(8'h6E, 1'b1, 1'b0, 1'b0, 1'b0, fr, n);
      fr[n-1] = 1'b0;
      rx_frame(fr, n, 8'h6E, 1'b0, 1'b1, "R8 single stop low");
      set_fmt(1'b1, 1'b1, 1'b0, 1'b0);
      build(8'h91, 1'b1, 1'b1, 1'b0, 1'b0, fr, n);
      fr[n-1] = 1'b0;
      rx_frame(fr, n, 8'h91, 1'b0, 1'b1, "R8 second stop low");
      build(8'h91, 1'b1, 1'b1, 1'b0, 1'b0, fr, n);
      fr[n-2] = 1'b0;
      rx_frame(fr, n, 8'h91, 1'b0, 1'b1, "R8 first stop low");
      build(8'h2D, 1'b1, 1'b1, 1'b0, 1'b0, fr, n);
      rx_frame(fr, n, 8'h2D, 1'b0, 1'b0, "R3 two good stops");

      // R7: short low pulse rejected, then a real frame is received
      set_fmt(1'b0, 1'b0, 1'b0, 1'b0);
      base = npulse;
      loop = 1'b0;
      @(negedge clk) rxd_drv = 1'b0;
      wait_ticks(3);
      @(negedge clk) rxd_drv = 1'b1;
      wait_ticks(200);
      @(negedge clk);
      chk(npulse == base, "R7 false start ignored", 32'(npulse - base), 0);
      build(8'hF7, 1'b0, 1'b0, 1'b0, 1'b0, fr, n);
      rx_frame(fr, n, 8'h77, 1'b0, 1'b0, "R7 R1 frame after glitch");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule